// File: doc/BRIEF.md
# Macroblock Frame-Buffer Address Generator

This block produces the read-address sequence that covers every word of one 4:2:0 macroblock stored in a packed, word-addressed frame buffer. Each word holds four 8-bit samples. Bits [7:0] hold the leftmost pixel and bits [31:24] hold the rightmost. The picture is 11 macroblocks wide and 9 high. Luma, Cb and Cr sit in three separate planes of one buffer that is 9504 words deep.

A client pulses the start input together with a macroblock index. One clock later the block begins to issue one address per clock with valid high. Each address carries tags for the plane, the row inside the macroblock and the word inside the row. When the last address has been issued, a one-cycle done pulse follows. The row and column of the macroblock are found once, when the start is accepted, with a comparator ladder and a constant multiply. The block has no divider.

Top module: `mbscan_top`

## Requirements
- R1: While reset is asserted, and after it is released until a start is accepted, `valid_o` and `done_o` are low.
- R2: A start is accepted when the block is not scanning and `mb_idx_i` is 98 or less. Starting in the following cycle, `valid_o` is high for exactly 96 consecutive cycles.
- R3: The first 64 addresses are luma, with `plane_o`=0, `row_o` running 0..15 and `word_o` running 0..3. Each address equals (m/11)*704 + (m%11)*4 + row*44 + word, where m is the index.
- R4: The next 16 addresses are Cb, with `plane_o`=1, `row_o` running 0..7 and `word_o` running 0..1. Each address equals 6336 + (m/11)*176 + (m%11)*2 + row*22 + word.
- R5: The last 16 addresses are Cr, with `plane_o`=2 and the same rows and words as Cb. Each address equals 7920 + (m/11)*176 + (m%11)*2 + row*22 + word.
- R6: Order: all luma rows, then all Cb rows, then all Cr rows. Rows go in ascending order. Inside a row, each word's address is one greater than the previous word's address.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the last valid address.
- R8: A start with an index above 98 is ignored. No valid address and no done pulse follow it.
- R9: A start that arrives while a scan is in progress is ignored. The running scan finishes unchanged, for the index it started with.
- R10: A start that arrives in the cycle in which `done_o` is high is accepted.
- R11: Every issued address is below 9504.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| mb_idx_i | input | 7 | Macroblock index, sampled with the start |
| addr_o | output | 14 | Word address into the frame buffer |
| valid_o | output | 1 | The address and its tags are valid |
| plane_o | output | 2 | Plane tag: 0 luma, 1 Cb, 2 Cr |
| row_o | output | 4 | Row inside the macroblock for this plane |
| word_o | output | 2 | Word inside the row |
| done_o | output | 1 | One-cycle pulse after the last address |

## Verification
The bench drives several kinds of macroblock index:
- Index 0 exercises the buffer origin.
- Index 98 is the last index in the picture, so it exercises the top of the address range.
- Index 10 ends a macroblock row, and index 11 begins the next one. This pair tells a correct column-to-row carry apart from one that is off by one.
- A mid-picture index exercises the general case.

Indices 99 and 127 show that out-of-range starts are rejected. A second start partway through a scan shows that the origin does not move. A start placed exactly in the done cycle shows that back-to-back scans are accepted. A behavioural reference model, built on division and remainder, is compared with every output on every clock.

// File: rtl/mbscan_pkg.sv
package mbscan_pkg;

  typedef enum logic [1:0] {
    PL_LUMA = 2'd0,
    PL_CB   = 2'd1,
    PL_CR   = 2'd2
  } plane_e;

  // Row of a macroblock in the picture, found with a comparator ladder.
  function automatic int unsigned mb_row_of(int unsigned idx,
                                            int unsigned cols,
                                            int unsigned rows);
    int unsigned r;
    r = 0;
    for (int unsigned k = 1; k < rows; k++)
      if (idx >= k * cols) r = k;
    return r;
  endfunction

  // Origin of a macroblock inside one plane.
  function automatic int unsigned mb_origin(int unsigned mrow,
                                            int unsigned mcol,
                                            int unsigned mb_row_step,
                                            int unsigned mb_col_step);
    return mrow * mb_row_step + mcol * mb_col_step;
  endfunction

  // Word address of (row, word) inside one macroblock of one plane.
  function automatic int unsigned word_addr(int unsigned plane_base,
                                            int unsigned origin,
                                            int unsigned stride,
                                            int unsigned row,
                                            int unsigned word);
    return plane_base + origin + row * stride + word;
  endfunction

endpackage

// File: rtl/mbscan_origin.sv
module mbscan_origin
  import mbscan_pkg::*;
#(
  parameter int MB_COLS   = 11,
  parameter int MB_ROWS   = 9,
  parameter int IDX_W     = 7,
  parameter int ADDR_W    = 14,
  parameter int LUMA_RSTP = 704,
  parameter int LUMA_CSTP = 4,
  parameter int CHR_RSTP  = 176,
  parameter int CHR_CSTP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] luma_org_o,
  output logic [ADDR_W-1:0] chroma_org_o
);

  int unsigned mrow, mcol;
  logic [ADDR_W-1:0] luma_org_d, chroma_org_d;

  always_comb begin
    mrow = mb_row_of(int'(idx_i), MB_COLS, MB_ROWS);
    mcol = int'(idx_i) - mrow * MB_COLS;
    luma_org_d   = ADDR_W'(mb_origin(mrow, mcol, LUMA_RSTP, LUMA_CSTP));
    chroma_org_d = ADDR_W'(mb_origin(mrow, mcol, CHR_RSTP, CHR_CSTP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_org_o   <= '0;
      chroma_org_o <= '0;
    end else if (load_i) begin
      luma_org_o   <= luma_org_d;
      chroma_org_o <= chroma_org_d;
    end
  end

endmodule

// File: rtl/mbscan_seq.sv
module mbscan_seq
  import mbscan_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int LAST_IDX = 98,
  parameter int L_ROWS   = 16,
  parameter int L_WORDS  = 4,
  parameter int C_ROWS   = 8,
  parameter int C_WORDS  = 2,
  parameter int ROW_W    = 4,
  parameter int WORD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              load_o,
  output logic              valid_o,
  output plane_e            plane_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);

  localparam int TOTAL  = L_ROWS * L_WORDS + 2 * C_ROWS * C_WORDS;
  localparam int CNT_W  = $clog2(TOTAL + 1);

  logic   active_q, done_q;
  plane_e plane_q;
  logic [ROW_W-1:0]  row_q;
  logic [WORD_W-1:0] word_q;

  logic idx_ok, word_end, row_end, last_beat;

  assign idx_ok   = int'(idx_i) <= LAST_IDX;
  assign load_o   = start_i && !active_q && idx_ok;
  assign word_end = (plane_q == PL_LUMA) ? (word_q == WORD_W'(L_WORDS - 1))
                                         : (word_q == WORD_W'(C_WORDS - 1));
  assign row_end  = (plane_q == PL_LUMA) ? (row_q == ROW_W'(L_ROWS - 1))
                                         : (row_q == ROW_W'(C_ROWS - 1));
  assign last_beat = active_q && word_end && row_end && (plane_q == PL_CR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      plane_q  <= PL_LUMA;
      row_q    <= '0;
      word_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        active_q <= 1'b1;
        plane_q  <= PL_LUMA;
        row_q    <= '0;
        word_q   <= '0;
      end else if (active_q) begin
        if (word_end) begin
          word_q <= '0;
          if (row_end) begin
            row_q <= '0;
            if (plane_q == PL_CR) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              plane_q <= (plane_q == PL_LUMA) ? PL_CB : PL_CR;
            end
          end else begin
            row_q <= row_q + 1'b1;
          end
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = active_q;
  assign plane_o = plane_q;
  assign row_o   = row_q;
  assign word_o  = word_q;
  assign done_o  = done_q;

  // Beat counter kept only for the span assertion.
  logic [CNT_W-1:0] beats_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beats_q <= '0;
    else if (load_o)   beats_q <= '0;
    else if (active_q) beats_q <= beats_q + 1'b1;
  end

  // R2
  span_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> beats_q == CNT_W'(TOTAL));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (done_o && !valid_o));

  // R8
  oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o && !idx_ok) |=> !valid_o);

endmodule

// File: rtl/mbscan_addr.sv
module mbscan_addr
  import mbscan_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 4,
  parameter int WORD_W   = 2,
  parameter int L_STRIDE = 44,
  parameter int C_STRIDE = 22,
  parameter int CB_BASE  = 6336,
  parameter int CR_BASE  = 7920
) (
  input  plane_e            plane_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] luma_org_i,
  input  logic [ADDR_W-1:0] chroma_org_i,
  output logic [ADDR_W-1:0] addr_o
);

  int unsigned base, origin, stride;

  always_comb begin
    unique case (plane_i)
      PL_CB:   begin base = CB_BASE; origin = int'(chroma_org_i); stride = C_STRIDE; end
      PL_CR:   begin base = CR_BASE; origin = int'(chroma_org_i); stride = C_STRIDE; end
      default: begin base = 0;       origin = int'(luma_org_i);   stride = L_STRIDE; end
    endcase
    addr_o = ADDR_W'(word_addr(base, origin, stride, int'(row_i), int'(word_i)));
  end

endmodule

// File: rtl/mbscan_top.sv
module mbscan_top
  import mbscan_pkg::*;
#(
  parameter int MB_COLS  = 11,
  parameter int MB_ROWS  = 9,
  parameter int WORD_PIX = 4,
  parameter int MB_PIX   = 16,
  parameter int IDX_W    = $clog2(MB_COLS * MB_ROWS),
  parameter int ADDR_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  mb_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic [1:0]        plane_o,
  output logic [3:0]        row_o,
  output logic [1:0]        word_o,
  output logic              done_o
);

  localparam int L_ROWS    = MB_PIX;
  localparam int L_WORDS   = MB_PIX / WORD_PIX;
  localparam int C_ROWS    = MB_PIX / 2;
  localparam int C_WORDS   = L_WORDS / 2;
  localparam int L_STRIDE  = MB_COLS * L_WORDS;
  localparam int C_STRIDE  = MB_COLS * C_WORDS;
  localparam int L_RSTP    = L_ROWS * L_STRIDE;
  localparam int C_RSTP    = C_ROWS * C_STRIDE;
  localparam int CB_BASE   = MB_ROWS * L_RSTP;
  localparam int CR_BASE   = CB_BASE + MB_ROWS * C_RSTP;
  localparam int DEPTH     = CR_BASE + MB_ROWS * C_RSTP;
  localparam int LAST_IDX  = MB_COLS * MB_ROWS - 1;
  localparam int ROW_W     = 4;
  localparam int WORD_W    = 2;

  logic              load;
  logic [ADDR_W-1:0] luma_org, chroma_org;
  plane_e            plane;

  mbscan_origin #(
    .MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .LUMA_RSTP(L_RSTP), .LUMA_CSTP(L_WORDS), .CHR_RSTP(C_RSTP), .CHR_CSTP(C_WORDS)
  ) u_origin (
    .clk(clk), .rst_n(rst_n), .load_i(load), .idx_i(mb_idx_i),
    .luma_org_o(luma_org), .chroma_org_o(chroma_org)
  );

  mbscan_seq #(
    .IDX_W(IDX_W), .LAST_IDX(LAST_IDX), .L_ROWS(L_ROWS), .L_WORDS(L_WORDS),
    .C_ROWS(C_ROWS), .C_WORDS(C_WORDS), .ROW_W(ROW_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(mb_idx_i),
    .load_o(load), .valid_o(valid_o), .plane_o(plane), .row_o(row_o),
    .word_o(word_o), .done_o(done_o)
  );

  mbscan_addr #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .WORD_W(WORD_W), .L_STRIDE(L_STRIDE),
    .C_STRIDE(C_STRIDE), .CB_BASE(CB_BASE), .CR_BASE(CR_BASE)
  ) u_addr (
    .plane_i(plane), .row_i(row_o), .word_i(word_o),
    .luma_org_i(luma_org), .chroma_org_i(chroma_org), .addr_o(addr_o)
  );

  assign plane_o = plane;

  // R11
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> int'(addr_o) < DEPTH);

  // R6
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && word_o != '0) |-> addr_o == $past(addr_o) + 1'b1);

  // R9
  origin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> ($stable(luma_org) && $stable(chroma_org)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !load) |=> !valid_o);

endmodule

// File: tb/mbscan_top_test.sv
module mbscan_top_test;

  typedef struct packed {
    int addr;
    int plane;
    int row;
    int word;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  mb_idx_i = '0;
  logic [13:0] addr_o;
  logic        valid_o;
  logic [1:0]  plane_o;
  logic [3:0]  row_o;
  logic [1:0]  word_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  beat_t q[$];
  logic exp_done = 1'b0;
  string ctx = "R1";

  always #4 clk = ~clk;

  mbscan_top uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mb_idx_i(mb_idx_i),
    .addr_o(addr_o), .valid_o(valid_o), .plane_o(plane_o), .row_o(row_o),
    .word_o(word_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  // Behavioural reference: the whole expected beat list is built from divisions.
  task automatic push_scan(input int m);
    int r, c;
    r = m / 11;
    c = m % 11;
    for (int y = 0; y < 16; y++)
      for (int k = 0; k < 4; k++)
        q.push_back('{r*704 + c*4 + y*44 + k, 0, y, k});
    for (int y = 0; y < 8; y++)
      for (int k = 0; k < 2; k++)
        q.push_back('{6336 + r*176 + c*2 + y*22 + k, 1, y, k});
    for (int y = 0; y < 8; y++)
      for (int k = 0; k < 2; k++)
        q.push_back('{7920 + r*176 + c*2 + y*22 + k, 2, y, k});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      exp_done <= 1'b0;
    end else begin
      bit idle;
      idle = (q.size() == 0);
      if (q.size() > 0) begin
        void'(q.pop_front());
        exp_done <= (q.size() == 0);
      end else begin
        exp_done <= 1'b0;
      end
      if (idle && start_i && mb_idx_i <= 7'd98) push_scan(int'(mb_idx_i));
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(valid_o == 1'b0, "R1", int'(valid_o), 0);
      check(done_o == 1'b0, "R1", int'(done_o), 0);
    end else begin
      check(valid_o == (q.size() > 0), "R2", int'(valid_o), int'(q.size() > 0));
      check(done_o == exp_done, "R7", int'(done_o), int'(exp_done));
      if (valid_o && q.size() > 0) begin
        beat_t e;
        string tg;
        e = q[0];
        tg = (e.plane == 0) ? "R3" : (e.plane == 1) ? "R4" : "R5";
        check(int'(addr_o) == e.addr, tg, int'(addr_o), e.addr);
        check(int'(plane_o) == e.plane, "R6", int'(plane_o), e.plane);
        check(int'(row_o) == e.row, "R6", int'(row_o), e.row);
        check(int'(word_o) == e.word, "R6", int'(word_o), e.word);
        check(int'(addr_o) < 9504, "R11", int'(addr_o), 9503);
      end
    end
  end

  task automatic pulse(input int idx);
    start_i  = 1'b1;
    mb_idx_i = 7'(idx);
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (!done_o && cycles < 100000);
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int vcount;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    ctx = "R3 idx0";   pulse(0);  wait_done(); @(negedge clk);
    ctx = "R5 idx98";  pulse(98); wait_done(); @(negedge clk);
    ctx = "R4 idx10";  pulse(10); wait_done(); @(negedge clk);
    ctx = "R4 idx11";  pulse(11); wait_done(); @(negedge clk);

    ctx = "R8 idx99";
    pulse(99);
    vcount = 0;
    repeat (10) begin
      if (valid_o || done_o) vcount++;
      @(negedge clk);
    end
    check(vcount == 0, "R8", vcount, 0);
    ctx = "R8 idx127";
    pulse(127);
    repeat (10) @(negedge clk);

    ctx = "R9 busy";
    pulse(54);
    repeat (30) @(negedge clk);
    pulse(3);
    vcount = 0;
    while (!done_o && cycles < 100000) begin
      if (valid_o) vcount++;
      @(negedge clk);
    end
    check(vcount == 96 - 31, "R9", vcount, 65);

    ctx = "R10 b2b";
    pulse(20);
    wait_done();
    pulse(87);
    vcount = 0;
    while (!done_o && cycles < 100000) begin
      if (valid_o) vcount++;
      @(negedge clk);
    end
    check(vcount == 96, "R10", vcount, 96);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cycles >= 100000);
    check(1'b0, "watchdog", cycles, 0);
    finish_run();
  end

endmodule